// File: doc/BRIEF.md
# Register-Mapped Receive FIFO Peripheral

This block is a 32-bit register slave built around a receive FIFO. Data does not come from a serial line. A side port at one bus offset loads 16-bit words into the FIFO, and the same bus drains them two bytes at a time. The register set covers data read, status, modem control, a baud divisor, a soft reset register and FIFO status flags. There is no line receiver, no transmitter, no parity logic and no baud generator. The divisor register only stores a value.

Four error conditions reach the status register through an injection input. A successful load raises a receive-interrupt status flag. When the interrupt enable in the modem control register is set and any flagged condition appears, the interrupt output gives a pulse of fixed length. Reading the status register returns its contents and then clears it. Writing one magic value to the reset register returns every register and the FIFO to the power-up state.

The bus has separate read and write strobes, each with its own address. One read and one write can therefore happen in the same cycle, including a pop together with a push.

Top module: `rxq_periph`

## Requirements
- R1: After reset, the registers read as follows:
  - modem control (0x08) reads 0x20;
  - baud divisor (0x0C) reads 0x43;
  - status (0x04), FIFO status (0x14) and reset register (0x10) read 0;
  - `irq` is low.
- R2: A write to 0x24 stores `wdata[15:8]` as the first byte and `wdata[7:0]` as the second. A read of 0x00 pops two bytes: the first goes to `rdata[15:8]`, the second to `rdata[7:0]`, and `rdata[31:16]` is 0. Words come out in the order they were loaded.
- R3: A byte popped from an empty FIFO reads as 0.
  - A pop that leaves the FIFO empty sets FIFO status bit 4 (0x10).
  - The same pop clears status bit 2 (overrun, 0x04).
- R4: An accepted load sets status bit 7 (0x80) and clears FIFO status bit 4.
- R5: `err_set[3:0]` sets status bits 3:0 (parity 0x01, framing 0x02, overrun 0x04, break 0x08).
  - A status read returns the value and clears the register, except for bits set in that same cycle.
  - Bits 5 and 6 read 0.
  - Writes to 0x04 have no visible effect.
- R6: A write to modem control with bit 5 (0x20) clear blocks all later loads until a reset, even if bit 5 is set again. A blocked load does not set status bit 7.
- R7: Let the condition be modem control bit 2 (0x04) set and at least one of status bits 7, 3, 2, 1, 0 set.
  - When the condition becomes true, `irq` is high for exactly `PULSE_CYC` consecutive cycles, starting one cycle after the status change.
  - With bit 2 clear, `irq` stays low.
- R8: The FIFO holds `DEPTH_BYTES` bytes.
  - FIFO status bit 5 (0x20) is set while the occupancy is at least `DEPTH_BYTES/2`.
  - A load into a full FIFO without a simultaneous pop is refused and sets FIFO status bit 6 (0x40).
  - Bit 6 clears on the next pop that removes data.
- R9: A write of 0 to the baud divisor is ignored. A non-zero write stores `wdata[15:0]`.
- R10: A write of exactly 0x55 to 0x10 restores every register and empties the FIFO. Any other value is stored and read back.
- R11: A pop and a load in the same cycle both take effect, including when the FIFO is full.
- R12: Read data is registered: `rdata` shows the addressed register in the cycle after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| bus_rdata | output | 32 | Registered read data |
| bus_wr | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| bus_wdata | input | 32 | Write data |
| err_set | input | 4 | Error flag injection, one bit per error status bit |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with `DEPTH_BYTES` = 16 and `PULSE_CYC` = 6. An eight-word FIFO lets the half-full threshold, the full condition, refused loads and a pop combined with a load at full occur within a few dozen bus operations. The short pulse makes the exact pulse width measurable in a small window. A seeded random mix of loads, pops and combined operations is compared against a queue model of contents and flags after every step.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [5:0] OFF_DATA  = 6'h00;
  localparam logic [5:0] OFF_STAT  = 6'h04;
  localparam logic [5:0] OFF_MODEM = 6'h08;
  localparam logic [5:0] OFF_BAUD  = 6'h0C;
  localparam logic [5:0] OFF_RST   = 6'h10;
  localparam logic [5:0] OFF_FSTAT = 6'h14;
  localparam logic [5:0] OFF_LOAD  = 6'h24;

  localparam logic [31:0] RESET_MAGIC = 32'h0000_0055;
  localparam logic [7:0]  MODEM_INIT  = 8'h20;
  localparam logic [15:0] BAUD_INIT   = 16'h0043;

  localparam int ST_RXI   = 7;
  localparam int ST_OVR   = 2;
  localparam int MDM_IEN  = 2;
  localparam int MDM_REN  = 5;

  // occupancy at or above half the capacity
  function automatic logic at_half(int occ_bytes, int depth_bytes);
    return (occ_bytes * 2) >= depth_bytes;
  endfunction

  // interrupt condition from status and modem control
  function automatic logic irq_wanted(logic [7:0] stat, logic [7:0] modem);
    return modem[MDM_IEN] && (stat[ST_RXI] || (|stat[3:0]));
  endfunction

  function automatic logic [7:0] fstat_pack(logic full, logic half, logic empty);
    return {1'b0, full, half, empty, 4'b0000};
  endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int ENTRIES = 1024,
  localparam int AW = $clog2(ENTRIES),
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [15:0]   push_data,
  input  logic          pop,
  output logic [15:0]   pop_data,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] count
);
  logic [15:0]   mem [ENTRIES];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          empty, full;

  assign empty    = (count == '0);
  assign full     = (count == CW'(ENTRIES));
  assign pop_ok   = pop && !empty && !clr;
  assign push_ok  = push && (!full || pop_ok) && !clr;
  assign pop_data = empty ? 16'h0000 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(ENTRIES));
  assert_full_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == $past(count)));
  assert_pair_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/rxq_pulse.sv
module rxq_pulse #(
  parameter int PULSE_CYC = 25,
  localparam int PW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cond,
  output logic irq
);
  logic          cond_q;
  logic          start;
  logic [PW-1:0] left;

  assign start = cond && !cond_q;
  assign irq   = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      left   <= '0;
    end else if (clr) begin
      cond_q <= 1'b0;
      left   <= '0;
    end else begin
      cond_q <= cond;
      if (start)     left <= PW'(PULSE_CYC);
      else if (irq)  left <= left - PW'(1);
    end
  end

  // checker: length of the current high run
  logic [PW:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_run <= '0;
    else if (!irq)                  hi_run <= '0;
    else if (hi_run <= PW'(PULSE_CYC)) hi_run <= hi_run + (PW+1)'(1);
  end

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= (PW+1)'(PULSE_CYC));
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cond));
endmodule

// File: rtl/rxq_periph.sv
module rxq_periph
  import rxq_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048,
  parameter int PULSE_CYC   = 25,
  parameter int ADDR_W      = 6,
  localparam int ENTRIES    = DEPTH_BYTES / 2,
  localparam int CW         = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       bus_rdata,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        err_set,
  output logic              irq
);
  logic [7:0]  stat_q, modem_q, rstv_q, stat_nx;
  logic [15:0] baud_q;
  logic        rx_en_q, fl_empty_q, fl_full_q;
  logic [15:0] pop_data;
  logic        push_ok, pop_ok;
  logic [CW-1:0] f_cnt;

  // decoded bus events
  logic soft_rst, wr_modem, wr_baud, wr_rstv, load_req, pop_req, stat_rd;
  logic pop_to_empty, load_refused, half_flag;
  logic [7:0] fstat;

  assign soft_rst = bus_wr && (6'(wr_addr) == OFF_RST) && (bus_wdata == RESET_MAGIC);
  assign wr_rstv  = bus_wr && (6'(wr_addr) == OFF_RST) && !soft_rst;
  assign wr_modem = bus_wr && (6'(wr_addr) == OFF_MODEM);
  assign wr_baud  = bus_wr && (6'(wr_addr) == OFF_BAUD) && (bus_wdata[15:0] != 16'h0);
  assign load_req = bus_wr && (6'(wr_addr) == OFF_LOAD) && rx_en_q;
  assign pop_req  = bus_rd && (6'(rd_addr) == OFF_DATA) && !soft_rst;
  assign stat_rd  = bus_rd && (6'(rd_addr) == OFF_STAT);

  assign pop_to_empty = pop_req && !push_ok && (f_cnt <= CW'(1));
  assign load_refused = load_req && !push_ok && !soft_rst;
  assign half_flag    = at_half(int'(f_cnt) * 2, DEPTH_BYTES);
  assign fstat        = fstat_pack(fl_full_q, half_flag, fl_empty_q);

  rxq_fifo #(.ENTRIES(ENTRIES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .push(load_req), .push_data(bus_wdata[15:0]),
    .pop(pop_req), .pop_data(pop_data),
    .push_ok(push_ok), .pop_ok(pop_ok), .count(f_cnt)
  );

  rxq_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .cond(irq_wanted(stat_q, modem_q)), .irq(irq)
  );

  always_comb begin
    stat_nx = stat_rd ? 8'h00 : stat_q;
    if (pop_to_empty) stat_nx[ST_OVR] = 1'b0;
    stat_nx[3:0] = stat_nx[3:0] | err_set;
    if (push_ok) stat_nx[ST_RXI] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 8'h00; modem_q <= MODEM_INIT; baud_q <= BAUD_INIT; rstv_q <= 8'h00;
      rx_en_q <= 1'b1; fl_empty_q <= 1'b0; fl_full_q <= 1'b0;
    end else if (soft_rst) begin
      stat_q <= 8'h00; modem_q <= MODEM_INIT; baud_q <= BAUD_INIT; rstv_q <= 8'h00;
      rx_en_q <= 1'b1; fl_empty_q <= 1'b0; fl_full_q <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      if (wr_modem) begin
        modem_q <= bus_wdata[7:0];
        if (!bus_wdata[MDM_REN]) rx_en_q <= 1'b0;
      end
      if (wr_baud) baud_q <= bus_wdata[15:0];
      if (wr_rstv) rstv_q <= bus_wdata[7:0];
      if (push_ok)           fl_empty_q <= 1'b0;
      else if (pop_to_empty) fl_empty_q <= 1'b1;
      if (load_refused)      fl_full_q <= 1'b1;
      else if (pop_ok)       fl_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 32'h0;
    else if (bus_rd) begin
      case (6'(rd_addr))
        OFF_DATA:  bus_rdata <= {16'h0, pop_data};
        OFF_STAT:  bus_rdata <= {24'h0, stat_q};
        OFF_MODEM: bus_rdata <= {24'h0, modem_q};
        OFF_BAUD:  bus_rdata <= {16'h0, baud_q};
        OFF_RST:   bus_rdata <= {24'h0, rstv_q};
        OFF_FSTAT: bus_rdata <= {24'h0, fstat};
        default:   bus_rdata <= 32'h0;
      endcase
    end
  end

  assert_stat_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !push_ok && (err_set == 4'h0) && !soft_rst) |=> (stat_q == 8'h00));
  assert_baud_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (6'(wr_addr) == OFF_BAUD) && (bus_wdata[15:0] == 16'h0)) |=> $stable(baud_q));
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((modem_q == MODEM_INIT) && (baud_q == BAUD_INIT) && (f_cnt == '0) && (stat_q == 8'h00)));
  assert_rx_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_q && !pop_req) |=> $stable(f_cnt));
endmodule

// File: tb/rxq_periph_test.sv
module rxq_periph_test;
  localparam int DEPTH = 16;
  localparam int WORDS = DEPTH / 2;
  localparam int PULSE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  rd_addr = '0, wr_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  err_set = '0;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;

  rxq_periph #(.DEPTH_BYTES(DEPTH), .PULSE_CYC(PULSE), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .rd_addr(rd_addr), .bus_rdata(bus_rdata),
    .bus_wr(bus_wr), .wr_addr(wr_addr), .bus_wdata(bus_wdata), .err_set(err_set), .irq(irq));

  always #5 clk = ~clk;

  // bench model
  logic [15:0] q[$];
  bit m_empty = 0, m_full = 0;

  function automatic logic [31:0] exp_fstat(int words, bit e, bit f);
    logic h;
    h = (words * 4 >= DEPTH);
    return {24'h0, 1'b0, f, h, e, 4'h0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; wr_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; rd_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic both(logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    bus_rd = 1'b1; rd_addr = 6'h00; bus_wr = 1'b1; wr_addr = 6'h24; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    r = bus_rdata;
  endtask

  task automatic count_irq(int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      if (irq) n++;
    end
  endtask

  task automatic pulse_err(logic [3:0] e);
    @(negedge clk);
    err_set = e;
    @(negedge clk);
    err_set = 4'h0;
  endtask

  // model step: do_push / do_pop, returns expected pop value
  task automatic model(bit do_push, bit do_pop, logic [15:0] d, output logic [15:0] pv);
    bit pop_ok, push_ok;
    pop_ok  = do_pop && (q.size() > 0);
    push_ok = do_push && ((q.size() < WORDS) || pop_ok);
    pv = pop_ok ? q.pop_front() : 16'h0;
    if (push_ok) q.push_back(d);
    if (push_ok) m_empty = 0;
    else if (do_pop && q.size() == 0) m_empty = 1;
    if (do_push && !push_ok) m_full = 1;
    else if (pop_ok) m_full = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] pv;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(6'h08, r); chk("R1 modem", r, 32'h20);
    rd(6'h0C, r); chk("R1 baud", r, 32'h43);
    // R12: registered read data: before edge old value, after edge new
    @(negedge clk); bus_rd = 1'b1; rd_addr = 6'h08;
    #1 chk("R12 before edge", bus_rdata, 32'h43);
    @(negedge clk); bus_rd = 1'b0;
    chk("R12 after edge", bus_rdata, 32'h20);
    rd(6'h04, r); chk("R1 status", r, 32'h0);
    rd(6'h14, r); chk("R1 fstat", r, 32'h0);
    rd(6'h10, r); chk("R1 rstreg", r, 32'h0);
    rd(6'h1C, r); chk("R12 unmapped", r, 32'h0);

    // R2 R4 load order and status
    wr(6'h24, 32'h0000_A1B2); wr(6'h24, 32'hFFFF_C3D4);
    rd(6'h14, r); chk("R4 empty cleared", r, 32'h0);
    rd(6'h04, r); chk("R4 rxi set", r, 32'h80);
    rd(6'h04, r); chk("R5 status cleared", r, 32'h0);
    wr(6'h04, 32'hFF); rd(6'h04, r); chk("R5 ctrl write no effect", r, 32'h0);
    rd(6'h00, r); chk("R2 first word", r, 32'h0000_A1B2);
    rd(6'h00, r); chk("R2 second word", r, 32'h0000_C3D4);
    rd(6'h14, r); chk("R3 empty set", r, 32'h10);
    rd(6'h00, r); chk("R3 empty pop zero", r, 32'h0);

    // R3 overrun cleared by pop to empty
    pulse_err(4'b0100);
    wr(6'h24, 32'h1234);
    rd(6'h00, r); chk("R2 single", r, 32'h1234);
    rd(6'h04, r); chk("R3 overrun cleared", r, 32'h80);
    // R5 error injection
    pulse_err(4'b1011);
    rd(6'h04, r); chk("R5 error bits", r, 32'h0B);
    rd(6'h04, r); chk("R5 cleared again", r, 32'h0);

    // R7 interrupt pulse
    wr(6'h08, 32'h24);
    wr(6'h24, 32'h5555);
    count_irq(20, n); chk("R7 pulse on load", n, PULSE);
    rd(6'h04, r);
    count_irq(20, n); chk("R7 no repeat", n, 0);
    pulse_err(4'b0010);
    count_irq(20, n); chk("R7 pulse on error", n, PULSE + 0);
    rd(6'h04, r);
    wr(6'h08, 32'h20);
    wr(6'h24, 32'h6666);
    count_irq(20, n); chk("R7 disabled no pulse", n, 0);
    rd(6'h04, r);
    rd(6'h00, r); chk("R2 drain a", r, 32'h5555);
    rd(6'h00, r); chk("R2 drain b", r, 32'h6666);
    m_empty = 1;

    // R9 baud
    wr(6'h0C, 32'h0); rd(6'h0C, r); chk("R9 zero ignored", r, 32'h43);
    wr(6'h0C, 32'h1234); rd(6'h0C, r); chk("R9 stored", r, 32'h1234);
    wr(6'h0C, 32'h0); rd(6'h0C, r); chk("R9 zero ignored again", r, 32'h1234);

    // R8 fill, half, full
    for (int i = 0; i < WORDS + 1; i++) begin
      wr(6'h24, 32'h100 + i);
      model(1, 0, 16'(32'h100 + i), pv);
      if (i == 3) begin rd(6'h14, r); chk("R8 half", r, exp_fstat(q.size(), m_empty, m_full)); end
    end
    rd(6'h14, r); chk("R8 full refused", r, 32'h60);
    rd(6'h00, r); model(0, 1, 16'h0, pv); chk("R8 first after full", r, {16'h0, pv});
    rd(6'h14, r); chk("R8 full cleared", r, 32'h20);
    // R11 pop and load at full-minus-one then at full
    wr(6'h24, 32'hBEEF); model(1, 0, 16'hBEEF, pv);
    both(32'hCAFE, r); model(1, 1, 16'hCAFE, pv); chk("R11 pop at full", r, {16'h0, pv});
    rd(6'h14, r); chk("R11 still full no flag", r, exp_fstat(q.size(), m_empty, m_full));
    while (q.size() > 0) begin
      rd(6'h00, r); model(0, 1, 16'h0, pv); chk("R11 drain", r, {16'h0, pv});
    end
    rd(6'h14, r); chk("R3 empty after drain", r, 32'h10);
    both(32'h7777, r); model(1, 1, 16'h7777, pv); chk("R11 pop empty with load", r, 32'h0);
    rd(6'h14, r); chk("R11 load kept", r, exp_fstat(q.size(), m_empty, m_full));

    // random phase
    for (int k = 0; k < 300; k++) begin
      int sel;
      logic [15:0] d;
      sel = $urandom % 20;
      d = 16'($urandom);
      if (sel < 9) begin
        wr(6'h24, {16'h0, d}); model(1, 0, d, pv);
      end else if (sel < 16) begin
        rd(6'h00, r); model(0, 1, 16'h0, pv); chk("R2 random pop", r, {16'h0, pv});
      end else begin
        both({16'h0, d}, r); model(1, 1, d, pv); chk("R11 random pair", r, {16'h0, pv});
      end
      rd(6'h14, r); chk("R8 random fstat", r, exp_fstat(q.size(), m_empty, m_full));
    end
    while (q.size() > 0) begin
      rd(6'h00, r); model(0, 1, 16'h0, pv); chk("R2 final drain", r, {16'h0, pv});
    end
    rd(6'h04, r);

    // R6 receive disable is sticky
    wr(6'h08, 32'h00);
    wr(6'h24, 32'h9999);
    rd(6'h04, r); chk("R6 no rxi when blocked", r, 32'h0);
    rd(6'h00, r); chk("R6 nothing stored", r, 32'h0);
    wr(6'h08, 32'h20);
    wr(6'h24, 32'h8888);
    rd(6'h00, r); chk("R6 still blocked", r, 32'h0);
    rd(6'h08, r); chk("R6 modem readback", r, 32'h20);

    // R10 soft reset
    wr(6'h10, 32'hAA); rd(6'h10, r); chk("R10 other value stored", r, 32'hAA);
    wr(6'h0C, 32'h0777); wr(6'h08, 32'h04);
    wr(6'h10, 32'h55);
    rd(6'h10, r); chk("R10 rstreg cleared", r, 32'h0);
    rd(6'h08, r); chk("R10 modem restored", r, 32'h20);
    rd(6'h0C, r); chk("R10 baud restored", r, 32'h43);
    rd(6'h14, r); chk("R10 fstat restored", r, 32'h0);
    wr(6'h24, 32'h4321);
    rd(6'h00, r); chk("R10 loading re-enabled", r, 32'h4321);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule